// File: doc/BRIEF.md
# DAC Conversion Sequencer with Refresh

This block feeds a two-channel digital-to-analog converter. Software-style writes go through a single port and reach one of three targets, chosen by a two-bit selector. The targets are a four-entry data FIFO, a mode word, and an output channel select. Once enabled, the sequencer waits out a programmable startup delay. After that it pops codes from the FIFO and sends each one to the converter with a one-cycle strobe, the code and a channel number. The channel is the select value in force on the cycle of issue.

Pacing has two modes. In normal mode the sequencer waits for the converter's end-of-conversion pulse, and a timeout bounds that wait. In max-speed mode it ignores that pulse and counts cycles internally, which brings consecutive conversions two clocks closer. A per-channel refresh timer reissues the last code sent to each channel, so the held analog level is renewed before it droops. A refresh period of zero turns refresh off.

Top module: `dac_seq`

## Requirements
- R1: After reset `tx_rdy_o` is 1, and `conv_strobe_o`, `done_o`, `ovf_o` and `tmo_o` are 0. A reset clears the FIFO, the refresh history, the mode word (all zero) and the channel select (0).
- R2: Write selector `wr_sel_i` takes 0 for data, 1 for mode and 2 for channel. The mode word has bit 0 = enable, bit 1 = max-speed, bits 9:2 = startup count S and bits 17:10 = refresh period P. A mode write that changes enable from 0 to 1 loads S. The first conversion can then issue no earlier than S+1 cycles after that write's capture edge. A mode write while already enabled does not restart the delay.
- R3: The FIFO holds 4 codes, and `tx_rdy_o` is low exactly while it is full. A data write while full is dropped, and it sets `ovf_o`, which stays set until reset.
- R4: Codes are converted in write order. Conversions start only while enabled and past the startup delay.
- R5: Each conversion drives `conv_chan_o` with the channel-select value (bit 0 of a channel write) held on its issue cycle, and drives `conv_data_o` with the code.
- R6: In normal mode the next strobe comes C+2 cycles after the previous one, where C = `CONV_CYC`. This assumes the converter returns `conv_eoc_i` C cycles after the strobe. The sequencer waits for `conv_eoc_i`, and `conv_strobe_o` lasts one cycle.
- R7: In max-speed mode consecutive strobes are exactly C cycles apart, and `conv_eoc_i` has no effect on pacing, on the timeout or on the interrupt.
- R8: In both modes `done_o` pulses for one cycle, C+1 cycles after the strobe. In max-speed mode this is two cycles after the internal counter has already let the next conversion go.
- R9: In normal mode, if no `conv_eoc_i` arrives within T = `TMO_CYC` cycles of a strobe, the conversion is abandoned. In that case `tmo_o` sets and stays set, no `done_o` pulse is given, and the next conversion may issue T+1 cycles after the strobe.
- R10: The refresh interval is R = P·2^`REF_SHIFT` cycles. A channel that has been converted since reset is converted again with its last code, R+1 cycles after its previous conversion, provided the sequencer is idle. Each conversion of a channel reloads that channel's own countdown. Channel 0 wins when both channels are due.
- R11: With P = 0 no refresh conversion issues.
- R12: A refresh issues only when the FIFO is empty, so pending data always goes before an overdue refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 data, 1 mode, 2 channel |
| wr_data_i | input | WW (18) | Write data |
| tx_rdy_o | output | 1 | FIFO not full |
| done_o | output | 1 | End-of-conversion interrupt pulse |
| ovf_o | output | 1 | Sticky FIFO overflow |
| tmo_o | output | 1 | Sticky end-of-conversion timeout |
| conv_strobe_o | output | 1 | Converter start strobe |
| conv_chan_o | output | CHW (1) | Converter channel |
| conv_data_o | output | DW (12) | Converter code |
| conv_eoc_i | input | 1 | End-of-conversion from converter |

## Verification
The bench builds the block with `CONV_CYC` = 6, `TMO_CYC` = 16 and `REF_SHIFT` = 2. With these values a refresh period of 5 gives a 20-cycle interval, and a timeout fires within a few dozen cycles. That keeps refresh repetition, the normal-to-max spacing difference of two cycles, and an abandoned conversion all short enough to time exactly, strobe by strobe. A converter stub echoes each strobe C cycles later as an end-of-conversion pulse, and it can be muted to force a timeout or to show that max-speed mode does not depend on the pulse.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam logic [1:0] WSEL_DATA = 2'd0;
  localparam logic [1:0] WSEL_MODE = 2'd1;
  localparam logic [1:0] WSEL_CHAN = 2'd2;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_WAIT  = 2'd1,
    PS_COUNT = 2'd2
  } pace_st_e;
endpackage

// File: rtl/dac_seq_fifo.sv
module dac_seq_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dac_seq_refresh.sv
module dac_seq_refresh #(
  parameter int DW        = 12,
  parameter int NCH       = 2,
  parameter int RPW       = 8,
  parameter int REF_SHIFT = 6,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RCW      = RPW + REF_SHIFT
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [RPW-1:0]          period_i,
  input  logic                    issue_i,
  input  logic [CHW-1:0]          issue_chan_i,
  input  logic [DW-1:0]           issue_data_i,
  output logic [NCH-1:0]          due_o,
  output logic [NCH-1:0][DW-1:0]  code_o
);
  logic [RCW-1:0] reload;
  logic           ref_on;

  assign reload = RCW'(period_i) << REF_SHIFT;
  assign ref_on = (period_i != '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0]  last_q;
    logic           seen_q;
    logic [RCW-1:0] cnt_q;
    logic           hit;

    assign hit       = issue_i && (issue_chan_i == CHW'(g));
    assign due_o[g]  = seen_q && ref_on && (cnt_q == '0);
    assign code_o[g] = last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        last_q <= '0;
        seen_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hit) begin
        last_q <= issue_data_i;
        seen_q <= 1'b1;
        cnt_q  <= reload;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_seq_pace.sv
module dac_seq_pace
  import dac_seq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int NCH      = 2,
  parameter int CONV_CYC = 25,
  parameter int TMO_CYC  = 64,
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CCW     = $clog2(CONV_CYC + 1),
  localparam int TW      = $clog2(TMO_CYC + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   started_i,
  input  logic                   maxs_i,
  input  logic                   fifo_empty_i,
  input  logic [DW-1:0]          fifo_data_i,
  input  logic [CHW-1:0]         sel_chan_i,
  input  logic [NCH-1:0]         ref_due_i,
  input  logic [NCH-1:0][DW-1:0] ref_code_i,
  input  logic                   eoc_i,
  output logic                   pop_o,
  output logic                   issue_o,
  output logic [CHW-1:0]         issue_chan_o,
  output logic [DW-1:0]          issue_data_o,
  output logic                   strobe_o,
  output logic [CHW-1:0]         chan_o,
  output logic [DW-1:0]          data_o,
  output logic                   done_o,
  output logic                   tmo_o
);
  pace_st_e       st_q;
  logic [CCW-1:0] cnt_q;
  logic [TW-1:0]  wcnt_q;
  logic           late0_q, late1_q;
  logic [CHW-1:0] ref_idx;
  logic           ref_any;

  // lowest-numbered due channel wins
  always_comb begin
    ref_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ref_due_i[i]) ref_idx = CHW'(i);
    end
  end
  assign ref_any = |ref_due_i;

  always_comb begin
    issue_o      = 1'b0;
    pop_o        = 1'b0;
    issue_chan_o = sel_chan_i;
    issue_data_o = fifo_data_i;
    if (st_q == PS_IDLE && started_i) begin
      if (!fifo_empty_i) begin
        issue_o = 1'b1;
        pop_o   = 1'b1;
      end else if (ref_any) begin
        issue_o      = 1'b1;
        issue_chan_o = ref_idx;
        issue_data_o = ref_code_i[ref_idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= PS_IDLE;
      cnt_q    <= '0;
      wcnt_q   <= '0;
      strobe_o <= 1'b0;
      chan_o   <= '0;
      data_o   <= '0;
      late0_q  <= 1'b0;
      late1_q  <= 1'b0;
      done_o   <= 1'b0;
      tmo_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      tmo_o    <= 1'b0;
      late0_q  <= 1'b0;
      late1_q  <= late0_q;
      done_o   <= late1_q;
      case (st_q)
        PS_IDLE: begin
          if (issue_o) begin
            strobe_o <= 1'b1;
            chan_o   <= issue_chan_o;
            data_o   <= issue_data_o;
            if (maxs_i) begin
              st_q  <= PS_COUNT;
              cnt_q <= CCW'(CONV_CYC - 1);
            end else begin
              st_q   <= PS_WAIT;
              wcnt_q <= '0;
            end
          end
        end
        PS_WAIT: begin
          if (eoc_i) begin
            st_q   <= PS_IDLE;
            done_o <= 1'b1;
          end else if (wcnt_q == TW'(TMO_CYC - 1)) begin
            st_q  <= PS_IDLE;
            tmo_o <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        PS_COUNT: begin
          if (cnt_q == CCW'(1)) begin
            st_q    <= PS_IDLE;
            late0_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_seq.sv
module dac_seq
  import dac_seq_pkg::*;
#(
  parameter int DW        = 12,
  parameter int DEPTH     = 4,
  parameter int NCH       = 2,
  parameter int SUW       = 8,
  parameter int RPW       = 8,
  parameter int REF_SHIFT = 6,
  parameter int CONV_CYC  = 25,
  parameter int TMO_CYC   = 64,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MW       = 2 + SUW + RPW,
  localparam int WW       = (DW > MW) ? DW : MW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [WW-1:0]  wr_data_i,
  output logic           tx_rdy_o,
  output logic           done_o,
  output logic           ovf_o,
  output logic           tmo_o,
  output logic           conv_strobe_o,
  output logic [CHW-1:0] conv_chan_o,
  output logic [DW-1:0]  conv_data_o,
  input  logic           conv_eoc_i
);
  localparam int SU_LSB = 2;
  localparam int RP_LSB = 2 + SUW;

  logic           en_q, maxs_q;
  logic [RPW-1:0] period_q;
  logic [SUW-1:0] su_cnt_q;
  logic [CHW-1:0] sel_q;
  logic           ovf_q, tmo_q;
  logic           started;

  logic           wr_data, wr_mode, wr_chan;
  logic           fifo_full, fifo_empty, fifo_pop;
  logic [DW-1:0]  fifo_data;
  logic           issue;
  logic [CHW-1:0] issue_chan;
  logic [DW-1:0]  issue_data;
  logic [NCH-1:0] ref_due;
  logic [NCH-1:0][DW-1:0] ref_code;
  logic           tmo_pulse;

  assign wr_data = wr_en_i && (wr_sel_i == WSEL_DATA);
  assign wr_mode = wr_en_i && (wr_sel_i == WSEL_MODE);
  assign wr_chan = wr_en_i && (wr_sel_i == WSEL_CHAN);
  assign started = en_q && (su_cnt_q == '0);
  assign tx_rdy_o = !fifo_full;
  assign ovf_o    = ovf_q;
  assign tmo_o    = tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      maxs_q   <= 1'b0;
      period_q <= '0;
      su_cnt_q <= '0;
      sel_q    <= '0;
      ovf_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      if (wr_mode) begin
        en_q     <= wr_data_i[0];
        maxs_q   <= wr_data_i[1];
        period_q <= wr_data_i[RP_LSB +: RPW];
      end
      // delay restarts only on an enable edge
      if (wr_mode && wr_data_i[0] && !en_q) su_cnt_q <= wr_data_i[SU_LSB +: SUW];
      else if (su_cnt_q != '0)               su_cnt_q <= su_cnt_q - 1'b1;
      if (wr_chan) sel_q <= wr_data_i[CHW-1:0];
      if (wr_data && fifo_full) ovf_q <= 1'b1;
      if (tmo_pulse) tmo_q <= 1'b1;
    end
  end

  dac_seq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .data_i  (wr_data_i[DW-1:0]),
    .pop_i   (fifo_pop),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  dac_seq_refresh #(.DW(DW), .NCH(NCH), .RPW(RPW), .REF_SHIFT(REF_SHIFT)) u_ref (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_i     (period_q),
    .issue_i      (issue),
    .issue_chan_i (issue_chan),
    .issue_data_i (issue_data),
    .due_o        (ref_due),
    .code_o       (ref_code)
  );

  dac_seq_pace #(.DW(DW), .NCH(NCH), .CONV_CYC(CONV_CYC), .TMO_CYC(TMO_CYC)) u_pace (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .started_i    (started),
    .maxs_i       (maxs_q),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .sel_chan_i   (sel_q),
    .ref_due_i    (ref_due),
    .ref_code_i   (ref_code),
    .eoc_i        (conv_eoc_i),
    .pop_o        (fifo_pop),
    .issue_o      (issue),
    .issue_chan_o (issue_chan),
    .issue_data_o (issue_data),
    .strobe_o     (conv_strobe_o),
    .chan_o       (conv_chan_o),
    .data_o       (conv_data_o),
    .done_o       (done_o),
    .tmo_o        (tmo_pulse)
  );
endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_strobe_i,
  input logic done_i,
  input logic ovf_i,
  input logic tmo_i,
  input logic tx_rdy_i,
  input logic started_i
);
  p_issue_after_startup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_i |-> $past(started_i));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(!tx_rdy_i));

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_i |=> !conv_strobe_i);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> tmo_i);

  p_tmo_no_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_i) |-> !done_i);
endmodule

bind dac_seq dac_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .conv_strobe_i (conv_strobe_o),
  .done_i        (done_o),
  .ovf_i         (ovf_o),
  .tmo_i         (tmo_o),
  .tx_rdy_i      (tx_rdy_o),
  .started_i     (started)
);

// File: tb/sim_dac_seq.sv
`timescale 1ns/1ps
module sim_dac_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, DEPTH = 4, NCH = 2, SUW = 8, RPW = 8;
  localparam int REF_SHIFT = 2, CONV = 6, TMO = 16;
  localparam int WW = 2 + SUW + RPW;

  // {channel, code}: stimulus and the expected converter-side result
  localparam logic [DW:0] VEC [6] = '{
    13'h0_123, 13'h1_456, 13'h1_FFF, 13'h0_000, 13'h0_A5A, 13'h1_001
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [WW-1:0] wr_data = '0;
  logic tx_rdy, done, ovf, tmo, strobe, eoc, kill = 1'b0;
  logic [0:0] chan;
  logic [DW-1:0] cdata;
  logic [CONV-1:0] sh;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int ns = 0, nd = 0;
  int st_cyc [64];
  int st_ch  [64];
  int st_dat [64];
  int dn_cyc [64];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_seq #(.DW(DW), .DEPTH(DEPTH), .NCH(NCH), .SUW(SUW), .RPW(RPW),
            .REF_SHIFT(REF_SHIFT), .CONV_CYC(CONV), .TMO_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tx_rdy_o(tx_rdy), .done_o(done), .ovf_o(ovf),
    .tmo_o(tmo), .conv_strobe_o(strobe), .conv_chan_o(chan),
    .conv_data_o(cdata), .conv_eoc_i(eoc)
  );

  // converter stub: end-of-conversion CONV cycles after the strobe
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[CONV-2:0], strobe};
  end
  assign eoc = sh[CONV-1] & ~kill;

  always @(negedge clk) begin
    if (rst_ni && strobe && ns < 64) begin
      st_cyc[ns] = cyc; st_ch[ns] = int'(chan); st_dat[ns] = int'(cdata); ns++;
    end
    if (rst_ni && done && nd < 64) begin
      dn_cyc[nd] = cyc; nd++;
    end
  end

  function automatic logic [WW-1:0] mode_w(bit en, bit mx, int s, int p);
    return {RPW'(p), SUW'(s), mx, en};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [WW-1:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; kill = 1'b0; wr_en = 1'b0;
    idle(3);
    ns = 0; nd = 0;
    rst_ni = 1'b1;
    idle(1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int e, e2, n0;
    do_reset();

    // R1 reset state
    chk(tx_rdy == 1'b1 && !strobe && !done && !ovf && !tmo, "R1 reset outputs",
        {tx_rdy, strobe, done, ovf, tmo}, 5'b10000);

    // R5 vector table: channel steering and code passthrough
    wr(2'd1, mode_w(1, 0, 0, 0), e);
    foreach (VEC[i]) begin
      wr(2'd2, WW'(VEC[i][DW]), e);
      wr(2'd0, WW'(VEC[i][DW-1:0]), e);
      idle(12);
      chk(ns == i + 1 && st_ch[i] == int'(VEC[i][DW]), "R5 channel", st_ch[i], int'(VEC[i][DW]));
      chk(st_dat[i] == int'(VEC[i][DW-1:0]), "R5 code", st_dat[i], int'(VEC[i][DW-1:0]));
    end

    // R2 startup delay and no restart while enabled
    do_reset();
    wr(2'd0, WW'(12'h123), e);
    idle(5);
    chk(ns == 0, "R4 no conversion while disabled", ns, 0);
    wr(2'd1, mode_w(1, 0, 7, 0), e);
    idle(20);
    chk(ns == 1 && st_cyc[0] - e == 8, "R2 startup delay", st_cyc[0] - e, 8);
    wr(2'd1, mode_w(1, 0, 7, 0), e2);
    wr(2'd0, WW'(12'h321), e);
    idle(15);
    chk(ns == 2 && st_cyc[1] - e == 1, "R2 no restart when enabled", st_cyc[1] - e, 1);

    // R3 FIFO depth/overflow, R4 order, R6 normal spacing, R8 done timing
    do_reset();
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, WW'(12'h0A0 + i), e);
      if (i == 3) chk(tx_rdy == 1'b0, "R3 not ready when full", tx_rdy, 0);
    end
    chk(ovf == 1'b1, "R3 overflow flag", ovf, 1);
    wr(2'd1, mode_w(1, 0, 0, 0), e);
    idle(60);
    chk(ns == 4, "R3 fifth word dropped", ns, 4);
    for (int i = 0; i < 4; i++)
      chk(st_dat[i] == 12'h0A0 + i, "R4 write order", st_dat[i], 12'h0A0 + i);
    chk(st_cyc[1] - st_cyc[0] == CONV + 2, "R6 normal spacing", st_cyc[1] - st_cyc[0], CONV + 2);
    chk(st_cyc[3] - st_cyc[2] == CONV + 2, "R6 normal spacing", st_cyc[3] - st_cyc[2], CONV + 2);
    chk(nd == 4 && dn_cyc[0] - st_cyc[0] == CONV + 1, "R8 done normal", dn_cyc[0] - st_cyc[0], CONV + 1);
    chk(tx_rdy == 1'b1 && ovf == 1'b1, "R3 ready again, overflow sticky", {tx_rdy, ovf}, 2'b11);

    // R7 max-speed spacing with end-of-conversion muted, R8 late interrupt
    do_reset();
    kill = 1'b1;
    for (int i = 0; i < 3; i++) wr(2'd0, WW'(12'h300 + i), e);
    wr(2'd1, mode_w(1, 1, 0, 0), e);
    idle(40);
    chk(ns == 3, "R7 all converted", ns, 3);
    chk(st_cyc[1] - st_cyc[0] == CONV, "R7 max spacing", st_cyc[1] - st_cyc[0], CONV);
    chk(st_cyc[2] - st_cyc[1] == CONV, "R7 max spacing", st_cyc[2] - st_cyc[1], CONV);
    chk(tmo == 1'b0, "R7 no timeout in max mode", tmo, 0);
    chk(nd == 3 && dn_cyc[1] - st_cyc[1] == CONV + 1, "R8 done max", dn_cyc[1] - st_cyc[1], CONV + 1);

    // R9 timeout
    do_reset();
    kill = 1'b1;
    wr(2'd0, WW'(12'h055), e);
    wr(2'd0, WW'(12'h066), e);
    wr(2'd1, mode_w(1, 0, 0, 0), e);
    idle(60);
    chk(ns == 2 && st_cyc[1] - st_cyc[0] == TMO + 1, "R9 timeout spacing", st_cyc[1] - st_cyc[0], TMO + 1);
    chk(tmo == 1'b1, "R9 timeout flag", tmo, 1);
    chk(nd == 0, "R9 no done on timeout", nd, 0);

    // R10 refresh of the last code on its channel
    do_reset();
    wr(2'd1, mode_w(1, 0, 0, 5), e);
    wr(2'd2, WW'(1), e);
    wr(2'd0, WW'(12'h2AB), e);
    idle(50);
    chk(ns == 3, "R10 refresh count", ns, 3);
    chk(st_cyc[1] - st_cyc[0] == 21 && st_cyc[2] - st_cyc[1] == 21, "R10 refresh interval",
        st_cyc[1] - st_cyc[0], 21);
    chk(st_ch[2] == 1 && st_dat[2] == 12'h2AB, "R10 refresh code/channel", st_dat[2], 12'h2AB);

    // R11 period zero disables refresh
    wr(2'd1, mode_w(1, 0, 0, 0), e);
    idle(10);
    n0 = ns;
    idle(100);
    chk(ns == n0, "R11 refresh off", ns, n0);

    // R12 data before an overdue refresh
    do_reset();
    wr(2'd1, mode_w(1, 0, 0, 2), e);
    wr(2'd0, WW'(12'h111), e);
    idle(30);
    wr(2'd1, mode_w(0, 0, 0, 2), e);
    idle(12);
    wr(2'd2, WW'(1), e);
    wr(2'd0, WW'(12'h222), e);
    idle(20);
    n0 = ns;
    wr(2'd1, mode_w(1, 0, 0, 2), e);
    idle(12);
    chk(ns >= n0 + 2, "R12 conversions after re-enable", ns, n0 + 2);
    chk(st_dat[n0] == 12'h222 && st_ch[n0] == 1, "R12 data first", st_dat[n0], 12'h222);
    chk(st_dat[n0+1] == 12'h111 && st_ch[n0+1] == 0, "R12 refresh after data", st_dat[n0+1], 12'h111);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule